// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vectorised load or store into a stream of per-element effective addresses. A single `start` pulse captures the vector length, the source and destination predicate masks, and the addressing configuration. The configuration covers the immediate or register form, the stride selection, the offset width and sign handling, the operation width, and which operands are scalar and which are vector. The block then walks the element indices. For each element it emits an address, the destination element index and, when base update is enabled, the update register index and the value to write back.

Four counters run side by side: source, destination, offset index and update. Each counter that belongs to a vector operand skips elements whose predicate bit is clear. The source mask governs the source, index and update counters, and the destination mask governs the destination counter. Results leave through a registered valid/ready slice that can issue one element per cycle. A one-cycle `done` pulse marks the end of the sequence. The base and offset register arrays and the immediate are read live and must stay steady while `busy` is high.

Top module: `vls_addr_seq`

## Requirements
- R1: In immediate form with a scalar base and `strideSel`=0, the address of element i is base[0] + immOff + i*B, where B is 1, 2, 4 or 8 bytes for `opWidth` codes 0, 1, 2, 3.
- R2: In immediate form with a scalar base and `strideSel`=1, the address is base[0] + i*immOff. A zero `immOff` therefore gives the same address for every element.
- R3: In immediate form with a vector base, the address is base[i] + immOff.
- R4: In register form, outside the R5 case, the address is base[baseIsVec ? i : 0] + off[offIsVec ? k : 0], where k is the offset-index counter.
- R5: In register form with `modeSel`=2'b01 and both base and offset scalar, the address is base[0] + off[0]*j, where j is the destination element index. Any other combination falls back to R4.
- R6: The register-form offset is cut to its `offWidth` (code 0=64, 1=32, 2=16, 3=8 bits). It is then sign-extended when `signedOff`=1 and zero-extended otherwise. The base always uses all 64 bits.
- R7: A stepping counter skips positions whose predicate bit is 0. The source counter steps in immediate form or with a vector base. The index counter steps with a vector offset. The destination counter steps with a vector destination. The update counter steps with a vector update operand.
- R8: With a scalar destination exactly one element is issued, with destination index 0.
- R9: When `updEnable`=1, `outUpdEn` is high and `outUpdData` equals `outAddr`. `outUpdIdx` follows the source mask when `updIsVec`=1 and is 0 otherwise.
- R10: The sequence ends once any stepping counter reaches the vector length, or at once when the length is 0. `done` then pulses for one cycle with `outValid` low.
- R11: While `outValid` is high and `outReady` is low, the outputs hold their values.
- R12: A `start` pulse while `busy` is high is ignored.
- R13: After reset `outValid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin a sequence |
| vecLen | input | IW | Vector length, 0..VLEN |
| srcMask | input | VLEN | Source predicate mask |
| dstMask | input | VLEN | Destination predicate mask |
| regForm | input | 1 | 0 = immediate form, 1 = register form |
| modeSel | input | 2 | Register-form mode bits (01 selects stride) |
| strideSel | input | 1 | Immediate form: 1 = element stride, 0 = unit stride |
| baseIsVec | input | 1 | Base operand is a vector |
| offIsVec | input | 1 | Offset operand is a vector |
| dstIsVec | input | 1 | Destination is a vector |
| updIsVec | input | 1 | Update target is a vector |
| updEnable | input | 1 | Base-update mode |
| signedOff | input | 1 | Sign-extend the register offset |
| offWidth | input | 2 | Offset width code |
| opWidth | input | 2 | Operation width code |
| immOff | input | XLEN | Immediate offset |
| baseRegs | input | VLEN*XLEN | Base register values, element e at bits e*XLEN |
| offRegs | input | VLEN*XLEN | Offset register values, element e at bits e*XLEN |
| busy | output | 1 | Sequence in progress |
| outValid | output | 1 | Element output valid |
| outReady | input | 1 | Consumer accepts element |
| outAddr | output | XLEN | Effective address |
| outDstIdx | output | IW | Destination element index |
| outUpdEn | output | 1 | Update write-back present |
| outUpdIdx | output | IW | Update register element index |
| outUpdData | output | XLEN | Update write-back value |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench aims at counters that must skip independently. If the source and destination masks have holes in different places, a design that shared one counter would emit wrong addresses or wrong destination indices. Splat with a zero immediate, register-form stride with a scalar-only qualification, and the narrowed offsets catch designs that use the wrong multiplier or extend the offset in the wrong way. A 16-bit negative offset must come out sign-extended under `signedOff` and zero-extended without it. A scalar destination that issued more than once, a zero length that issued anything, a start while busy that restarted the run, or outputs that changed under backpressure would each show up as extra, missing or mismatched entries in the scoreboard.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef struct packed {
    logic load;
    logic issue;
  } ctlStrobe_t;

  typedef struct packed {
    logic exhausted;
    logic dstScalar;
  } dpStatus_t;

  typedef struct packed {
    logic       regForm;
    logic [1:0] modeSel;
    logic       strideSel;
    logic       baseIsVec;
    logic       offIsVec;
    logic       dstIsVec;
    logic       updIsVec;
    logic       updEnable;
    logic       signedOff;
    logic [1:0] offWidth;
    logic [1:0] opWidth;
  } seqCfg_t;

endpackage

// File: rtl/vls_addr_ctrl.sv
module vls_addr_ctrl
  import vls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       outReady,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       outValid,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t state;
  logic      stopFlag;
  logic      slotFree;
  logic      finish;

  assign slotFree = !outValid || outReady;
  assign busy     = (state == ST_RUN);

  always_comb begin
    strobe.load  = (state == ST_IDLE) && start;
    strobe.issue = (state == ST_RUN) && slotFree && !stopFlag && !status.exhausted;
    finish       = (state == ST_RUN) && slotFree && (stopFlag || status.exhausted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stopFlag <= 1'b0;
      outValid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (strobe.load) begin
        state    <= ST_RUN;
        stopFlag <= 1'b0;
      end else if (finish) begin
        state <= ST_IDLE;
      end
      if (strobe.issue) begin
        stopFlag <= status.dstScalar;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vls_addr_dp.sv
module vls_addr_dp
  import vls_pkg::*;
#(
  parameter int VLEN = 16,
  parameter int XLEN = 64,
  parameter int IW   = $clog2(VLEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobe_t           strobe,
  input  seqCfg_t              cfgIn,
  input  logic [IW-1:0]        vecLen,
  input  logic [VLEN-1:0]      srcMask,
  input  logic [VLEN-1:0]      dstMask,
  input  logic [XLEN-1:0]      immOff,
  input  logic [VLEN*XLEN-1:0] baseRegs,
  input  logic [VLEN*XLEN-1:0] offRegs,
  output dpStatus_t            status,
  output seqCfg_t              cfgQ,
  output logic [IW-1:0]        vlQ,
  output logic [XLEN-1:0]      addrQ,
  output logic [IW-1:0]        dstIdxQ,
  output logic [IW-1:0]        updIdxQ,
  output logic                 updEnQ
);

  localparam logic [IW-1:0] NONE = IW'(VLEN);

  logic [VLEN-1:0] srcMaskQ, dstMaskQ;
  logic [IW-1:0]   ctrI, ctrJ, ctrK, ctrU;
  logic [IW-1:0]   effI, effJ, effK, effU;
  logic            stepI, stepJ, stepK, stepU;
  logic [XLEN-1:0] baseSel, base0, offSel, off0Ext, offSelExt, addrNext;

  // lowest set position at or above cur and below the length, else NONE
  function automatic logic [IW-1:0] nextSet(input logic [VLEN-1:0] m,
                                            input logic [IW-1:0] cur,
                                            input logic [IW-1:0] len);
    logic [IW-1:0] res;
    res = NONE;
    for (int p = VLEN - 1; p >= 0; p--) begin
      if (IW'(p) >= cur && IW'(p) < len && m[p]) res = IW'(p);
    end
    return res;
  endfunction

  function automatic logic [XLEN-1:0] pick(input logic [VLEN*XLEN-1:0] regs,
                                           input logic [IW-1:0] idx);
    logic [XLEN-1:0] val;
    val = '0;
    for (int e = 0; e < VLEN; e++) begin
      if (idx == IW'(e)) val = regs[e*XLEN +: XLEN];
    end
    return val;
  endfunction

  function automatic logic [XLEN-1:0] extendOff(input logic [XLEN-1:0] v,
                                                input logic [1:0] code,
                                                input logic sgn);
    logic [XLEN-1:0] res;
    int              keep;
    keep = (code == 2'd0) ? XLEN : (64 >> code);
    res  = '0;
    for (int b = 0; b < XLEN; b++) begin
      if (b < keep) res[b] = v[b];
      else          res[b] = sgn & v[keep-1];
    end
    return res;
  endfunction

  always_comb begin
    stepI = !cfgQ.regForm || cfgQ.baseIsVec;
    stepK = cfgQ.regForm && cfgQ.offIsVec;
    stepJ = cfgQ.dstIsVec;
    stepU = cfgQ.updEnable && cfgQ.updIsVec;
    effI  = stepI ? nextSet(srcMaskQ, ctrI, vlQ) : ctrI;
    effK  = stepK ? nextSet(srcMaskQ, ctrK, vlQ) : ctrK;
    effU  = stepU ? nextSet(srcMaskQ, ctrU, vlQ) : ctrU;
    effJ  = stepJ ? nextSet(dstMaskQ, ctrJ, vlQ) : ctrJ;
    status.exhausted = (vlQ == '0) || (stepI && effI >= vlQ) || (stepK && effK >= vlQ)
                     || (stepU && effU >= vlQ) || (stepJ && effJ >= vlQ);
    status.dstScalar = !cfgQ.dstIsVec;
  end

  always_comb begin
    base0     = baseRegs[XLEN-1:0];
    baseSel   = pick(baseRegs, cfgQ.baseIsVec ? effI : '0);
    offSel    = pick(offRegs, cfgQ.offIsVec ? effK : '0);
    off0Ext   = extendOff(offRegs[XLEN-1:0], cfgQ.offWidth, cfgQ.signedOff);
    offSelExt = extendOff(offSel, cfgQ.offWidth, cfgQ.signedOff);
    if (!cfgQ.regForm) begin
      if (cfgQ.baseIsVec)      addrNext = baseSel + immOff;
      else if (cfgQ.strideSel) addrNext = base0 + XLEN'(effI) * immOff;
      else                     addrNext = base0 + immOff + (XLEN'(effI) << cfgQ.opWidth);
    end else if (cfgQ.modeSel == 2'b01 && !cfgQ.baseIsVec && !cfgQ.offIsVec) begin
      addrNext = base0 + off0Ext * XLEN'(effJ);
    end else begin
      addrNext = baseSel + offSelExt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ     <= '0;
      vlQ      <= '0;
      srcMaskQ <= '0;
      dstMaskQ <= '0;
      ctrI     <= '0;
      ctrJ     <= '0;
      ctrK     <= '0;
      ctrU     <= '0;
      addrQ    <= '0;
      dstIdxQ  <= '0;
      updIdxQ  <= '0;
      updEnQ   <= 1'b0;
    end else if (strobe.load) begin
      cfgQ     <= cfgIn;
      vlQ      <= vecLen;
      srcMaskQ <= srcMask;
      dstMaskQ <= dstMask;
      ctrI     <= '0;
      ctrJ     <= '0;
      ctrK     <= '0;
      ctrU     <= '0;
    end else if (strobe.issue) begin
      ctrI    <= stepI ? effI + 1'b1 : ctrI;
      ctrJ    <= stepJ ? effJ + 1'b1 : ctrJ;
      ctrK    <= stepK ? effK + 1'b1 : ctrK;
      ctrU    <= stepU ? effU + 1'b1 : ctrU;
      addrQ   <= addrNext;
      dstIdxQ <= effJ;
      updIdxQ <= effU;
      updEnQ  <= cfgQ.updEnable;
    end
  end

endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
  import vls_pkg::*;
#(
  parameter int VLEN = 16,
  parameter int XLEN = 64,
  localparam int IW  = $clog2(VLEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IW-1:0]        vecLen,
  input  logic [VLEN-1:0]      srcMask,
  input  logic [VLEN-1:0]      dstMask,
  input  logic                 regForm,
  input  logic [1:0]           modeSel,
  input  logic                 strideSel,
  input  logic                 baseIsVec,
  input  logic                 offIsVec,
  input  logic                 dstIsVec,
  input  logic                 updIsVec,
  input  logic                 updEnable,
  input  logic                 signedOff,
  input  logic [1:0]           offWidth,
  input  logic [1:0]           opWidth,
  input  logic [XLEN-1:0]      immOff,
  input  logic [VLEN*XLEN-1:0] baseRegs,
  input  logic [VLEN*XLEN-1:0] offRegs,
  output logic                 busy,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [XLEN-1:0]      outAddr,
  output logic [IW-1:0]        outDstIdx,
  output logic                 outUpdEn,
  output logic [IW-1:0]        outUpdIdx,
  output logic [XLEN-1:0]      outUpdData,
  output logic                 done
);

  ctlStrobe_t    strobe;
  dpStatus_t     status;
  seqCfg_t       cfgIn;
  seqCfg_t       dpCfg;
  logic [IW-1:0] dpVl;

  always_comb begin
    cfgIn.regForm   = regForm;
    cfgIn.modeSel   = modeSel;
    cfgIn.strideSel = strideSel;
    cfgIn.baseIsVec = baseIsVec;
    cfgIn.offIsVec  = offIsVec;
    cfgIn.dstIsVec  = dstIsVec;
    cfgIn.updIsVec  = updIsVec;
    cfgIn.updEnable = updEnable;
    cfgIn.signedOff = signedOff;
    cfgIn.offWidth  = offWidth;
    cfgIn.opWidth   = opWidth;
  end

  vls_addr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe),
    .busy     (busy),
    .outValid (outValid),
    .done     (done)
  );

  vls_addr_dp #(.VLEN(VLEN), .XLEN(XLEN), .IW(IW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cfgIn    (cfgIn),
    .vecLen   (vecLen),
    .srcMask  (srcMask),
    .dstMask  (dstMask),
    .immOff   (immOff),
    .baseRegs (baseRegs),
    .offRegs  (offRegs),
    .status   (status),
    .cfgQ     (dpCfg),
    .vlQ      (dpVl),
    .addrQ    (outAddr),
    .dstIdxQ  (outDstIdx),
    .updIdxQ  (outUpdIdx),
    .updEnQ   (outUpdEn)
  );

  assign outUpdData = outAddr;

endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
  parameter int XLEN = 64,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            outValid,
  input logic            outReady,
  input logic [XLEN-1:0] outAddr,
  input logic [IW-1:0]   outDstIdx,
  input logic [IW-1:0]   outUpdIdx,
  input logic            done,
  input logic            cfgDstVec,
  input logic [IW-1:0]   cfgVl
);

  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outDstIdx) && $stable(outUpdIdx));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !outValid && !busy);

  a_r8_scalar_dst_once: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && !cfgDstVec |=> !outValid);

  a_r7_dst_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && cfgDstVec |=> !outValid || (outDstIdx > $past(outDstIdx)));

  a_r10_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outDstIdx < cfgVl);

endmodule

bind vls_addr_seq vls_addr_seq_chk #(.XLEN(XLEN), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .outValid  (outValid),
  .outReady  (outReady),
  .outAddr   (outAddr),
  .outDstIdx (outDstIdx),
  .outUpdIdx (outUpdIdx),
  .done      (done),
  .cfgDstVec (dpCfg.dstIsVec),
  .cfgVl     (dpVl)
);

// File: tb/vls_addr_seq_bench.sv
module vls_addr_seq_bench;

  localparam int VLEN = 16;
  localparam int XLEN = 64;
  localparam int IW   = $clog2(VLEN + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [IW-1:0]        vecLen = '0;
  logic [VLEN-1:0]      srcMask = '0, dstMask = '0;
  logic                 regForm = 0, strideSel = 0, baseIsVec = 0, offIsVec = 0;
  logic                 dstIsVec = 0, updIsVec = 0, updEnable = 0, signedOff = 0;
  logic [1:0]           modeSel = '0, offWidth = '0, opWidth = '0;
  logic [XLEN-1:0]      immOff = '0;
  logic [VLEN*XLEN-1:0] baseRegs, offRegs;
  logic                 busy, outValid, outReady, outUpdEn, done;
  logic [XLEN-1:0]      outAddr, outUpdData;
  logic [IW-1:0]        outDstIdx, outUpdIdx;

  int errors = 0;
  int checks = 0;
  string curReq = "R13";
  logic stallMode = 1'b0;
  logic [XLEN-1:0] qAddr[$];
  int qDst[$];
  int qUpd[$];

  always #4 clk = ~clk;

  vls_addr_seq u_vls_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen), .srcMask(srcMask),
    .dstMask(dstMask), .regForm(regForm), .modeSel(modeSel), .strideSel(strideSel),
    .baseIsVec(baseIsVec), .offIsVec(offIsVec), .dstIsVec(dstIsVec), .updIsVec(updIsVec),
    .updEnable(updEnable), .signedOff(signedOff), .offWidth(offWidth), .opWidth(opWidth),
    .immOff(immOff), .baseRegs(baseRegs), .offRegs(offRegs), .busy(busy),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outDstIdx(outDstIdx),
    .outUpdEn(outUpdEn), .outUpdIdx(outUpdIdx), .outUpdData(outUpdData), .done(done)
  );

  task automatic check(input string req, input string what, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  // R6 offset narrowing
  function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v);
    case (offWidth)
      2'd1: return signedOff ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
      2'd2: return signedOff ? {{48{v[15]}}, v[15:0]} : {48'b0, v[15:0]};
      2'd3: return signedOff ? {{56{v[7]}}, v[7:0]} : {56'b0, v[7:0]};
      default: return v;
    endcase
  endfunction

  // reference model of the element walk, built from R1..R10
  task automatic buildExpect();
    int i = 0, j = 0, k = 0, u = 0;
    bit sI, sJ, sK, sU;
    logic [XLEN-1:0] a;
    sI = !regForm || baseIsVec;
    sK = regForm && offIsVec;
    sJ = dstIsVec;
    sU = updEnable && updIsVec;
    forever begin
      if (sI) while (i < vecLen && !srcMask[i]) i++;
      if (sK) while (k < vecLen && !srcMask[k]) k++;
      if (sU) while (u < vecLen && !srcMask[u]) u++;
      if (sJ) while (j < vecLen && !dstMask[j]) j++;
      if (vecLen == 0 || (sI && i >= vecLen) || (sK && k >= vecLen) ||
          (sU && u >= vecLen) || (sJ && j >= vecLen)) break;
      if (!regForm) begin
        if (baseIsVec)      a = baseRegs[i*XLEN +: XLEN] + immOff;
        else if (strideSel) a = baseRegs[XLEN-1:0] + XLEN'(i) * immOff;
        else                a = baseRegs[XLEN-1:0] + immOff + XLEN'(i) * (XLEN'(1) << opWidth);
      end else if (modeSel == 2'b01 && !baseIsVec && !offIsVec) begin
        a = baseRegs[XLEN-1:0] + narrow(offRegs[XLEN-1:0]) * XLEN'(j);
      end else begin
        a = baseRegs[(baseIsVec ? i : 0)*XLEN +: XLEN] + narrow(offRegs[(offIsVec ? k : 0)*XLEN +: XLEN]);
      end
      qAddr.push_back(a);
      qDst.push_back(j);
      qUpd.push_back(u);
      if (!dstIsVec) break;
      if (sI) i++;
      if (sJ) j++;
      if (sK) k++;
      if (sU) u++;
    end
  endtask

  // ready pattern, changed just after each rising edge
  logic [7:0] readyPat = 8'b1011_0110;
  always @(posedge clk) begin
    #1;
    readyPat <= {readyPat[6:0], readyPat[7] ^ readyPat[5]};
    outReady <= stallMode ? readyPat[0] : 1'b1;
  end

  // monitor: scoreboard and hold check
  logic            prevStall = 1'b0;
  logic [XLEN-1:0] prevAddr;
  logic [IW-1:0]   prevDst;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevStall) begin
        check("R11", "held valid", XLEN'(outValid), XLEN'(1));
        check("R11", "held addr", outAddr, prevAddr);
        check("R11", "held dst", XLEN'(outDstIdx), XLEN'(prevDst));
      end
      prevStall = outValid && !outReady;
      prevAddr  = outAddr;
      prevDst   = outDstIdx;
      if (outValid && outReady) begin
        if (qAddr.size() == 0) begin
          check(curReq, "unexpected element", XLEN'(1), XLEN'(0));
        end else begin
          check(curReq, "addr", outAddr, qAddr.pop_front());
          check(curReq, "dst index", XLEN'(outDstIdx), XLEN'(qDst.pop_front()));
          if (updEnable) begin
            check("R9", "upd index", XLEN'(outUpdIdx), XLEN'(qUpd.pop_front()));
            check("R9", "upd en", XLEN'(outUpdEn), XLEN'(1));
            check("R9", "upd data", outUpdData, outAddr);
          end else begin
            void'(qUpd.pop_front());
          end
        end
      end
    end
  end

  task automatic runJob(input string req, input bit poke);
    bit seenDone = 0;
    curReq = req;
    buildExpect();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: a second start with another length while busy
      vecLen = 1;
      dstIsVec = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c < 400; c++) begin
      if (done) begin
        seenDone = 1;
        check("R10", "outValid at done", XLEN'(outValid), XLEN'(0));
        break;
      end
      @(negedge clk);
    end
    check("R10", "done pulse seen", XLEN'(seenDone), XLEN'(1));
    @(negedge clk);
    check("R10", "done one cycle", XLEN'(done), XLEN'(0));
    check(req, "elements left", XLEN'(qAddr.size()), XLEN'(0));
    qAddr.delete();
    qDst.delete();
    qUpd.delete();
  endtask

  task automatic setCfg(input bit rf, input bit bv, input bit ov, input bit dv, input bit st);
    regForm = rf; baseIsVec = bv; offIsVec = ov; dstIsVec = dv; strideSel = st;
    modeSel = 2'b00; updEnable = 0; updIsVec = 0; signedOff = 0; offWidth = 0;
    opWidth = 0; srcMask = '1; dstMask = '1;
  endtask

  initial begin
    for (int e = 0; e < VLEN; e++) begin
      baseRegs[e*XLEN +: XLEN] = 64'h0000_0001_0000_0000 + 64'(e) * 64'h340;
      offRegs[e*XLEN +: XLEN]  = {48'h00AB_CDEF_1234, 16'hFF00 + 16'(e) * 16'h11};
    end
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R13", "outValid reset", XLEN'(outValid), XLEN'(0));
    check("R13", "done reset", XLEN'(done), XLEN'(0));
    check("R13", "busy reset", XLEN'(busy), XLEN'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unit stride, 4-byte and 8-byte
    setCfg(0, 0, 0, 1, 0); vecLen = 5; opWidth = 2; immOff = 64'h20;
    runJob("R1", 0);
    opWidth = 3; vecLen = 7; stallMode = 1;
    runJob("R1", 0);

    // R7 different holes in source and destination masks
    setCfg(0, 0, 0, 1, 0); vecLen = 12; opWidth = 1; immOff = 64'h8;
    srcMask = 16'b0000_1011_0110_1101; dstMask = 16'b0000_1110_1011_0111;
    runJob("R7", 0);

    // R2 element stride and zero-immediate splat
    setCfg(0, 0, 0, 1, 1); vecLen = 6; immOff = 64'd24;
    runJob("R2", 0);
    immOff = 64'd0; vecLen = 9;
    runJob("R2", 0);

    // R3 vector base with immediate
    setCfg(0, 1, 0, 1, 0); vecLen = 8; immOff = 64'hFFFF_FFFF_FFFF_FFF0;
    srcMask = 16'b1111_0000_1101_1011;
    runJob("R3", 0);

    // R4 register indexed, both vector, full-width offset
    setCfg(1, 1, 1, 1, 0); vecLen = 10; srcMask = 16'b0011_1101_0111_1110;
    runJob("R4", 0);

    // R6 16-bit offsets, signed then unsigned
    setCfg(1, 1, 1, 1, 0); vecLen = 6; offWidth = 2; signedOff = 1;
    runJob("R6", 0);
    signedOff = 0;
    runJob("R6", 0);
    offWidth = 3; signedOff = 1;
    runJob("R6", 0);

    // R5 register element stride and its fallback
    setCfg(1, 0, 0, 1, 0); modeSel = 2'b01; offWidth = 2; vecLen = 5;
    dstMask = 16'b1111_1111_1110_1101;
    runJob("R5", 0);
    offIsVec = 1;
    runJob("R5", 0);

    // R8 scalar destination issues once
    setCfg(0, 0, 0, 0, 0); vecLen = 8; immOff = 64'h40; opWidth = 2;
    runJob("R8", 0);
    setCfg(1, 1, 1, 0, 0); vecLen = 8; srcMask = 16'b1111_1111_1111_1100;
    runJob("R8", 0);

    // R9 update mode, vector then scalar update target
    setCfg(0, 1, 0, 1, 0); vecLen = 9; immOff = 64'h10; updEnable = 1; updIsVec = 1;
    srcMask = 16'b0000_0001_1010_1110;
    runJob("R9", 0);
    updIsVec = 0;
    runJob("R9", 0);

    // R10 zero length
    setCfg(0, 0, 0, 1, 0); vecLen = 0;
    runJob("R10", 0);

    // R12 start while busy ignored
    stallMode = 0;
    setCfg(0, 0, 0, 1, 1); vecLen = 7; immOff = 64'd12;
    runJob("R12", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired during %s", curReq);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule